// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by an integer N = P*B + A, where P is the prescaler base modulus (32 by default), B is the main period count and A is the swallow count. Inside, a prescaler counter divides by P+1 or by P under control of a modulus line. A sequencer counts prescaler periods. Each output cycle begins with A periods at P+1 and ends with B-A periods at P. At the end of every output cycle the block emits one single-cycle pulse. With P = 32, every integer ratio from 992 upward to 262143 can be reached.

A setting is written with a one-cycle strobe. A legal setting (B at least 3, A no greater than B) is staged and takes effect at the next output-cycle boundary, so the cycle in progress keeps its length. An illegal setting raises an error flag and is discarded, and the last legal setting stays in force. Two hold inputs stop the divider. The counter-reset input parks it and leaves a staged setting waiting for a boundary. The load-state input parks it and makes any write take effect at once. Counting restarts from a fresh cycle on the first clock edge that sees the hold released.

The sequencer has three states. IDLE is entered from reset or whenever a hold input is high. SWALLOW drives the modulus line high, and MAIN drives it low. IDLE goes to SWALLOW on release when A is non-zero, and to MAIN when A is zero. SWALLOW goes to MAIN after A prescaler periods when B > A. SWALLOW ends the cycle directly when B = A. MAIN ends the cycle after B-A periods. A cycle end re-enters SWALLOW or MAIN according to the setting now in force. Any state goes to IDLE while a hold input is high.

Top module: `swallow_divider`

## Requirements
- R1: Successive rising edges of `div_pulse` are exactly P*B + A clock cycles apart, where B and A are the setting in force for that cycle.
- R2: `div_pulse` is high for exactly one clock cycle per output cycle.
- R3: Within each output cycle, `mod_hi` is high for exactly A*(P+1) clock cycles at the start of the cycle. When A = 0 it stays low.
- R4: When B equals A, `mod_hi` stays high for the whole output cycle of length P*B + A.
- R5: A write with B < 3 or A > B sets `cfg_err` from the next cycle on and leaves the setting in force unchanged. `cfg_err` changes only on a write.
- R6: A legal write clears `cfg_err`. While counting, a legal write takes effect only at the next output-cycle boundary, and the cycle in progress keeps its length.
- R7: While `cnt_rst` is high, `div_pulse` and `mod_hi` stay low and a staged setting is not applied. The first pulse after release comes P*B + A + 1 edges after the release, counting the first edge that samples `cnt_rst` low as edge 1, and uses the old setting. The staged setting governs the next cycle.
- R8: While `load_hold` is high, `div_pulse` and `mod_hi` stay low. A staged or newly written legal setting takes effect at once, so the first cycle after release uses it.
- R9: During reset, `div_pulse`, `mod_hi` and `cfg_err` are low. The setting in force after reset is B = P-1, A = 0, and counting starts on the first edge after reset release.
- R10: The largest setting, B all ones and A = P-1, is legal and gives N = P*2^B_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Counter reset: parks the divider and keeps staged settings waiting |
| load_hold | input | 1 | Load state: parks the divider and applies settings immediately |
| cfg_wr | input | 1 | One-cycle write strobe for `cfg_b` and `cfg_a` |
| cfg_b | input | B_W | Main period count B |
| cfg_a | input | log2(P) | Swallow count A |
| div_pulse | output | 1 | One-cycle pulse at each output-cycle boundary |
| mod_hi | output | 1 | Modulus control: high selects divide by P+1 |
| cfg_err | output | 1 | Last write was rejected as illegal |

## Verification
A wrong period count or prescaler reload shows up at once as a pulse spacing that differs from P*B + A, on the first output cycle after the fault. A swallow phase of the wrong length shows in the number of `mod_hi` cycles within that same output cycle. A staging fault shows as a spacing change one cycle early or one cycle late, around a write or a hold release, so it appears within two output cycles. The bench sweeps every B and A of a small configuration (P = 4, B_W = 4) and compares each spacing and each modulus count with arithmetic on the written values.

// File: rtl/psd_pkg.sv
package psd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psd_state_e;
endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage #(
    parameter int PRESC = 32,
    parameter int B_W   = 13,
    localparam int A_W  = $clog2(PRESC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [B_W-1:0] wr_b,
    input  logic [A_W-1:0] wr_a,
    input  logic           direct,
    input  logic           boundary,
    output logic [B_W-1:0] act_b,
    output logic [A_W-1:0] act_a,
    output logic [B_W-1:0] nxt_b,
    output logic [A_W-1:0] nxt_a,
    output logic           err
);
    localparam logic [B_W-1:0] B_MIN = B_W'(3);
    localparam logic [B_W-1:0] B_RST = B_W'(PRESC - 1);

    logic [B_W-1:0] pend_b;
    logic [A_W-1:0] pend_a;
    logic           pend_vld;
    logic           legal;

    assign legal = (wr_b >= B_MIN) && (B_W'(wr_a) <= wr_b);
    assign nxt_b = pend_vld ? pend_b : act_b;
    assign nxt_a = pend_vld ? pend_a : act_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_b    <= B_RST;
            act_a    <= '0;
            pend_b   <= B_RST;
            pend_a   <= '0;
            pend_vld <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (wr) begin
                err <= !legal;
            end
            if (direct) begin
                if (wr && legal) begin
                    act_b <= wr_b;
                    act_a <= wr_a;
                end else if (pend_vld) begin
                    act_b <= pend_b;
                    act_a <= pend_a;
                end
                pend_vld <= 1'b0;
            end else begin
                if (boundary && pend_vld) begin
                    act_b <= pend_b;
                    act_a <= pend_a;
                end
                if (wr && legal) begin
                    pend_b   <= wr_b;
                    pend_a   <= wr_a;
                    pend_vld <= 1'b1;
                end else if (boundary) begin
                    pend_vld <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int PRESC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mod_nxt,
    output logic tick
);
    localparam int PW = $clog2(PRESC + 1);
    localparam logic [PW-1:0] P_HI = PW'(PRESC);
    localparam logic [PW-1:0] P_LO = PW'(PRESC - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] pcnt;

    assign tick = run && (pcnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= P_LO;
        end else if (!run || tick) begin
            pcnt <= mod_nxt ? P_HI : P_LO;
        end else begin
            pcnt <= pcnt - ONE;
        end
    end
endmodule

// File: rtl/psd_sequencer.sv
module psd_sequencer
    import psd_pkg::*;
#(
    parameter int PRESC = 32,
    parameter int B_W   = 13,
    localparam int A_W  = $clog2(PRESC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt,
    input  logic           tick,
    input  logic [B_W-1:0] act_b,
    input  logic [A_W-1:0] act_a,
    input  logic [B_W-1:0] nxt_b,
    input  logic [A_W-1:0] nxt_a,
    output psd_state_e     state,
    output logic           mod_nxt,
    output logic           boundary,
    output logic           pulse,
    output logic           mod_hi
);
    localparam logic [B_W-1:0] ONE_B = B_W'(1);

    psd_state_e     state_n;
    logic [B_W-1:0] pc;
    logic [B_W-1:0] pc_n;

    // next-state and period-count logic
    always_comb begin
        state_n  = state;
        pc_n     = pc;
        boundary = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (act_a != '0) begin
                    state_n = ST_SWALLOW;
                    pc_n    = B_W'(act_a) - ONE_B;
                end else begin
                    state_n = ST_MAIN;
                    pc_n    = act_b - ONE_B;
                end
            end
            ST_SWALLOW: begin
                if (tick) begin
                    if (pc != '0) begin
                        pc_n = pc - ONE_B;
                    end else if (act_b == B_W'(act_a)) begin
                        boundary = 1'b1;
                    end else begin
                        state_n = ST_MAIN;
                        pc_n    = act_b - B_W'(act_a) - ONE_B;
                    end
                end
            end
            ST_MAIN: begin
                if (tick) begin
                    if (pc != '0) begin
                        pc_n = pc - ONE_B;
                    end else begin
                        boundary = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (boundary) begin
            if (nxt_a != '0) begin
                state_n = ST_SWALLOW;
                pc_n    = B_W'(nxt_a) - ONE_B;
            end else begin
                state_n = ST_MAIN;
                pc_n    = nxt_b - ONE_B;
            end
        end
        if (halt) begin
            state_n  = ST_IDLE;
            pc_n     = pc;
            boundary = 1'b0;
        end
    end

    assign mod_nxt = (state_n == ST_SWALLOW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else begin
            state <= state_n;
            pc    <= pc_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= boundary;
        end
    end

    assign mod_hi = (state == ST_SWALLOW);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import psd_pkg::*;
#(
    parameter int PRESC = 32,
    parameter int B_W   = 13,
    localparam int A_W  = $clog2(PRESC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_rst,
    input  logic           load_hold,
    input  logic           cfg_wr,
    input  logic [B_W-1:0] cfg_b,
    input  logic [A_W-1:0] cfg_a,
    output logic           div_pulse,
    output logic           mod_hi,
    output logic           cfg_err
);
    logic [B_W-1:0] act_b;
    logic [A_W-1:0] act_a;
    logic [B_W-1:0] nxt_b;
    logic [A_W-1:0] nxt_a;
    logic           halt;
    logic           tick;
    logic           mod_nxt;
    logic           boundary;
    psd_state_e     state;

    assign halt = cnt_rst || load_hold;

    psd_cfg_stage #(.PRESC(PRESC), .B_W(B_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wr_b     (cfg_b),
        .wr_a     (cfg_a),
        .direct   (load_hold),
        .boundary (boundary),
        .act_b    (act_b),
        .act_a    (act_a),
        .nxt_b    (nxt_b),
        .nxt_a    (nxt_a),
        .err      (cfg_err)
    );

    psd_prescaler #(.PRESC(PRESC)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != ST_IDLE),
        .mod_nxt (mod_nxt),
        .tick    (tick)
    );

    psd_sequencer #(.PRESC(PRESC), .B_W(B_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .tick     (tick),
        .act_b    (act_b),
        .act_a    (act_a),
        .nxt_b    (nxt_b),
        .nxt_a    (nxt_a),
        .state    (state),
        .mod_nxt  (mod_nxt),
        .boundary (boundary),
        .pulse    (div_pulse),
        .mod_hi   (mod_hi)
    );
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter int PRESC = 32,
    parameter int B_W   = 13,
    localparam int A_W  = $clog2(PRESC)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cnt_rst,
    input logic           load_hold,
    input logic           cfg_wr,
    input logic [B_W-1:0] cfg_b,
    input logic [A_W-1:0] cfg_a,
    input logic           div_pulse,
    input logic           mod_hi,
    input logic           cfg_err
);
    localparam logic [31:0] MIN_GAP = 32'(3 * PRESC - 1);

    logic        bad_wr;
    logic [31:0] gap;

    assign bad_wr = cfg_wr && ((cfg_b < B_W'(3)) || (B_W'(cfg_a) > cfg_b));

    // clocks since the last pulse or hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (div_pulse || cnt_rst || load_hold) begin
            gap <= '0;
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 32'd1;
        end
    end

    p_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (gap >= MIN_GAP));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> cfg_err);

    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_err));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !bad_wr) |=> !cfg_err);

    p_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (!div_pulse && !mod_hi));

    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_hold |=> (!div_pulse && !mod_hi));
endmodule

bind swallow_divider swallow_divider_chk #(.PRESC(PRESC), .B_W(B_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_rst   (cnt_rst),
    .load_hold (load_hold),
    .cfg_wr    (cfg_wr),
    .cfg_b     (cfg_b),
    .cfg_a     (cfg_a),
    .div_pulse (div_pulse),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err)
);

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
    localparam int P  = 4;
    localparam int BW = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_rst = 1'b0;
    logic          load_hold = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [BW-1:0] cfg_b = '0;
    logic [AW-1:0] cfg_a = '0;
    logic          div_pulse;
    logic          mod_hi;
    logic          cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swallow_divider #(.PRESC(P), .B_W(BW)) u_swallow_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_rst   (cnt_rst),
        .load_hold (load_hold),
        .cfg_wr    (cfg_wr),
        .cfg_b     (cfg_b),
        .cfg_a     (cfg_a),
        .div_pulse (div_pulse),
        .mod_hi    (mod_hi),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts edges until div_pulse is seen, and mod_hi cycles along the way
    task automatic wait_pulse(output int n, output int m);
        n = 0;
        m = 0;
        while (n < 2000) begin
            if (mod_hi) m++;
            @(posedge clk); #1;
            n++;
            if (div_pulse) break;
        end
    endtask

    task automatic wr(input int b, input int a);
        cfg_b  = BW'(b);
        cfg_a  = AW'(a);
        cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    function automatic int nval(input int b, input int a);
        return P * b + a;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int m;
        int cur_b;
        int cur_a;
        bit legal;

        repeat (3) @(posedge clk);
        #1;
        check(div_pulse == 1'b0, "R9 pulse in reset", int'(div_pulse), 0);
        check(mod_hi == 1'b0, "R9 mod in reset", int'(mod_hi), 0);
        check(cfg_err == 1'b0, "R9 err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        cur_b = P - 1;
        cur_a = 0;
        wait_pulse(n, m);
        check(n == nval(cur_b, cur_a) + 1, "R9 first latency", n, nval(cur_b, cur_a) + 1);
        check(m == 0, "R9 mod count", m, 0);
        wait_pulse(n, m);
        check(n == nval(cur_b, cur_a), "R1 reset setting period", n, nval(cur_b, cur_a));

        // exhaustive sweep through the load-state path
        for (int b = 0; b < (1 << BW); b++) begin
            for (int a = 0; a < P; a++) begin
                load_hold = 1'b1;
                @(posedge clk); #1;
                wr(b, a);
                legal = (b >= 3) && (a <= b);
                check(cfg_err == !legal, "R5 R6 err flag", int'(cfg_err), int'(!legal));
                if (legal) begin
                    cur_b = b;
                    cur_a = a;
                end
                load_hold = 1'b0;
                wait_pulse(n, m);
                check(n == nval(cur_b, cur_a) + 1, "R8 first cycle after hold", n, nval(cur_b, cur_a) + 1);
                check(m == cur_a * (P + 1), "R3 mod cycles first", m, cur_a * (P + 1));
                wait_pulse(n, m);
                check(n == nval(cur_b, cur_a), "R1 period", n, nval(cur_b, cur_a));
                check(m == cur_a * (P + 1), "R3 mod cycles", m, cur_a * (P + 1));
                if (cur_b == cur_a) begin
                    check(m == n, "R4 full swallow cycle", m, n);
                end
                if (legal && b == (1 << BW) - 1 && a == P - 1) begin
                    check(n == P * (1 << BW) - 1, "R10 largest ratio", n, P * (1 << BW) - 1);
                end
                @(posedge clk); #1;
                check(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
            end
        end

        // boundary staging while counting
        load_hold = 1'b1;
        @(posedge clk); #1;
        wr(5, 2);
        load_hold = 1'b0;
        wait_pulse(n, m);
        wr(7, 1);
        check(cfg_err == 1'b0, "R6 legal write err", int'(cfg_err), 0);
        wait_pulse(n, m);
        check(n == nval(5, 2) - 1, "R6 current cycle kept", n, nval(5, 2) - 1);
        wait_pulse(n, m);
        check(n == nval(7, 1), "R6 new setting at boundary", n, nval(7, 1));
        wr(2, 0);
        check(cfg_err == 1'b1, "R5 illegal B while counting", int'(cfg_err), 1);
        wait_pulse(n, m);
        check(n == nval(7, 1) - 1, "R5 setting kept", n, nval(7, 1) - 1);
        wait_pulse(n, m);
        check(n == nval(7, 1), "R5 setting kept next", n, nval(7, 1));
        wr(9, 3);
        check(cfg_err == 1'b0, "R6 err cleared", int'(cfg_err), 0);
        wait_pulse(n, m);
        check(n == nval(7, 1) - 1, "R6 cycle kept again", n, nval(7, 1) - 1);
        wait_pulse(n, m);
        check(n == nval(9, 3), "R6 applied", n, nval(9, 3));

        // counter reset keeps the staged setting waiting
        wr(4, 0);
        cnt_rst = 1'b1;
        begin
            int noisy = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk); #1;
                if (div_pulse || mod_hi) noisy++;
            end
            check(noisy == 0, "R7 quiet under counter reset", noisy, 0);
        end
        cnt_rst = 1'b0;
        wait_pulse(n, m);
        check(n == nval(9, 3) + 1, "R7 old setting after release", n, nval(9, 3) + 1);
        check(m == 3 * (P + 1), "R7 mod cycles after release", m, 3 * (P + 1));
        wait_pulse(n, m);
        check(n == nval(4, 0), "R7 staged setting next", n, nval(4, 0));

        // load state applies a staged setting at once
        wr(6, 2);
        load_hold = 1'b1;
        begin
            int noisy = 0;
            for (int i = 0; i < 6; i++) begin
                @(posedge clk); #1;
                if (div_pulse || mod_hi) noisy++;
            end
            check(noisy == 0, "R8 quiet under load state", noisy, 0);
        end
        load_hold = 1'b0;
        wait_pulse(n, m);
        check(n == nval(6, 2) + 1, "R8 staged applied at once", n, nval(6, 2) + 1);
        wait_pulse(n, m);
        check(n == nval(6, 2), "R8 period", n, nval(6, 2));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule